// File: doc/BRIEF.md
# Traversal-Stack Pop-Streak Prefetch Generator

This block sits next to the per-thread traversal storage of a tree walker, where each entry holds the address of a node still to be visited. It watches the push and pop events that the walker sends to that storage. From these events it produces a stream of cache prefetch addresses. Every address it issues is read from an entry that is still held in the storage. The block never forms an address of its own and never predicts one.

In depth-first mode the storage is a stack. A run of consecutive pops means the walk is climbing back up the tree, so the entries just below the top will be needed soon. Each thread keeps a 2-bit streak level and a single pointer. The streak level sets how many entries under the top to prefetch. The pointer records how far down the stack prefetching has already reached in the current run, so that no entry is issued twice. In breadth-first mode the storage is a FIFO, and the block prefetches a fixed number of entries starting at the head. The storage sits outside the block and is reached through a combinational read port. Prefetch addresses leave the block one per cycle on a valid/ready handshake and are meant for the first-level cache.

Top module: `ttp_prefetch_gen`

## Requirements
- R1: In reset, and afterwards until a pop or dequeue gives it work, `pf_valid_o` stays low.
- R2: In depth-first mode (`bfs_mode_i`=0), an event is a pop when `ev_pop_i`=1 and a push when `ev_pop_i`=0. `ev_count_i` carries the occupancy after the event, and stack position 0 is the bottom. The first pop after a push makes the block prefetch only the new top entry, at position `ev_count_i`-1. While no other event arrives and the output is free, `pf_valid_o` rises on the clock edge that follows the edge taking the pop.
- R3: On the second consecutive pop, the block covers the two entries below the top, issuing them top-first. It skips any entry already issued earlier in the run.
- R4: On the third and every later consecutive pop, the block covers up to PF_CAP entries (default 4) below the top, issuing them top-first. No entry is issued twice within one run.
- R5: A push ends a run. The streak returns to zero, any prefetches of that thread not yet issued are dropped, and pushes themselves never cause a prefetch. The next pop behaves as the first pop of a run.
- R6: No prefetch is ever issued for a position below the bottom of the stack, and none for a position that is not occupied.
- R7: In breadth-first mode (`bfs_mode_i`=1), an event is a dequeue when `ev_pop_i`=1 and an enqueue when `ev_pop_i`=0, and queue position 0 is the head. The block prefetches positions 0 up to BFS_AHEAD-1 (default 4), each entry once, and never reaches past the tail. A dequeue moves the window forward by one position. An enqueue adds an entry to the window only when the queue held fewer than BFS_AHEAD entries.
- R8: At most one address leaves per cycle. While `pf_valid_o`=1 and `pf_ready_i`=0, the values on `pf_addr_o` and `pf_tid_o` stay unchanged. No new address is loaded in a cycle in which an event is presented.
- R9: Each thread, selected by `ev_tid_i`, keeps its own streak and pointer. When several threads have work at once, the threads are served in round-robin order, starting from thread 0 after reset.
- R10: A change of `bfs_mode_i` clears the streak, occupancy and pointer of every thread. No prefetch is issued from the state that existed before the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bfs_mode_i | input | 1 | 0 selects depth-first (stack), 1 selects breadth-first (FIFO) |
| ev_valid_i | input | 1 | A push/pop event is presented this cycle |
| ev_pop_i | input | 1 | 1 for pop/dequeue, 0 for push/enqueue |
| ev_tid_i | input | TID_W | Thread whose storage the event touched |
| ev_count_i | input | CNT_W | Occupancy of that thread's storage after the event |
| rd_tid_o | output | TID_W | Thread whose storage entry is read |
| rd_idx_o | output | CNT_W | Position read (bottom-based for stack, head-based for queue) |
| rd_addr_i | input | ADDR_W | Node address held at the read position |
| pf_valid_o | output | 1 | Prefetch address is valid |
| pf_ready_i | input | 1 | Cache side accepts the prefetch |
| pf_tid_o | output | TID_W | Thread the prefetch belongs to |
| pf_addr_o | output | ADDR_W | Prefetch node address |

## Verification
An event changes a thread's state on the edge that takes it. The first prefetch caused by that event appears on `pf_valid_o` one edge later. After that, with `pf_ready_i` high, each further entry follows one edge after the one before. An event presented while a prefetch is waiting delays the next load by that one cycle. The bench presents its inputs on the falling edge and checks all outputs on the next falling edge, which is half a period after the rising edge that updated them. Its expected address sequences are therefore counted edge by edge from these latencies. Hold behaviour is checked by keeping ready low across several cycles and checking that the same address and thread remain on the output.

// File: rtl/ttp_pkg.sv
// Shared types for the pop-streak prefetch generator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package ttp_pkg;

    // Pop-streak level kept per thread (2 bits)
    typedef enum logic [1:0] {
        STREAK_IDLE = 2'd0,
        STREAK_ONE  = 2'd1,
        STREAK_TWO  = 2'd2,
        STREAK_DEEP = 2'd3
    } streak_e;

    // Advance the streak by one pop, saturating at the deep level
    function automatic streak_e streak_step(input streak_e cur);
        case (cur)
            STREAK_IDLE: return STREAK_ONE;
            STREAK_ONE:  return STREAK_TWO;
            default:     return STREAK_DEEP;
        endcase
    endfunction

endpackage

// File: rtl/ttp_streak_slot.sv
// Per-thread state of the prefetch generator: streak level, occupancy copy
// and one prefetch pointer. Reports whether an entry is waiting and which
// position it is. Depth-first: the pointer is the lowest stack position
// already issued in the current run (or the occupancy after a push), so
// issue walks downward. Breadth-first: the pointer counts head entries
// already issued, so issue walks toward the tail.
// Assumes no event and no take arrive for this thread in the same cycle.
module ttp_streak_slot
    import ttp_pkg::*;
#(
    parameter int STACK_DEPTH = 16,
    parameter int PF_CAP      = 4,
    parameter int BFS_AHEAD   = 4,
    localparam int CNT_W      = $clog2(STACK_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             bfs_i,
    input  logic             hit_i,
    input  logic             pop_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             take_i,
    output logic             pend_o,
    output logic [CNT_W-1:0] cand_o
);

    localparam logic [CNT_W-1:0] CAP_C   = CNT_W'(PF_CAP);
    localparam logic [CNT_W-1:0] AHEAD_C = CNT_W'(BFS_AHEAD);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO_C   = CNT_W'(2);

    streak_e          lvl_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ptr_q;
    logic [CNT_W-1:0] depth;
    logic [CNT_W-1:0] lowest;
    logic [CNT_W-1:0] limit;

    // Window of positions the current streak or queue mode allows
    always_comb begin
        case (lvl_q)
            STREAK_ONE:  depth = ONE_C;
            STREAK_TWO:  depth = TWO_C;
            STREAK_DEEP: depth = CAP_C;
            default:     depth = '0;
        endcase
        lowest = (cnt_q > depth) ? (cnt_q - depth) : '0;
        limit  = (cnt_q < AHEAD_C) ? cnt_q : AHEAD_C;
        if (bfs_i) begin
            pend_o = (ptr_q < limit);
            cand_o = ptr_q;
        end else begin
            pend_o = (lvl_q != STREAK_IDLE) && (ptr_q > lowest);
            cand_o = ptr_q - ONE_C;
        end
    end

    // State update on events, issued entries, mode change and reset
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            lvl_q <= STREAK_IDLE;
            cnt_q <= '0;
            ptr_q <= '0;
        end else if (hit_i) begin
            cnt_q <= count_i;
            if (bfs_i) begin
                if (pop_i && (ptr_q != '0)) begin
                    ptr_q <= ptr_q - ONE_C;
                end
            end else if (pop_i) begin
                lvl_q <= streak_step(lvl_q);
                ptr_q <= (ptr_q < count_i) ? ptr_q : count_i;
            end else begin
                lvl_q <= STREAK_IDLE;
                ptr_q <= count_i;
            end
        end else if (take_i) begin
            ptr_q <= bfs_i ? (ptr_q + ONE_C) : (ptr_q - ONE_C);
        end
    end

    AST_PUSH_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i && !pop_i && !bfs_i && !clr_i |=> !pend_o); // R5
    AST_POP_ARMS_STREAK: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i && pop_i && !bfs_i && !clr_i |=> lvl_q != STREAK_IDLE); // R3
    AST_TAKE_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> pend_o && !hit_i); // R8
    AST_DFS_IN_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && !bfs_i |-> cand_o < cnt_q); // R6
    AST_BFS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && bfs_i |-> (cand_o < AHEAD_C) && (cand_o < cnt_q)); // R7

endmodule

// File: rtl/ttp_rr_pick.sv
// Round-robin choice among threads that have a prefetch waiting.
// The search starts one past the thread served last; after reset it
// starts at thread 0. The pointer moves only when a grant is used.
module ttp_rr_pick #(
    parameter int N     = 4,
    localparam int ID_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req_i,
    input  logic            adv_i,
    output logic            any_o,
    output logic [N-1:0]    gnt_o,
    output logic [ID_W-1:0] gnt_id_o
);

    logic [ID_W-1:0] last_q;

    // Rotating search for the first requesting thread after the last one
    always_comb begin
        int j;
        j        = 0;
        any_o    = 1'b0;
        gnt_o    = '0;
        gnt_id_o = '0;
        for (int off = 1; off <= N; off++) begin
            j = (int'(last_q) + off) % N;
            if (!any_o && req_i[j]) begin
                any_o    = 1'b1;
                gnt_o[j] = 1'b1;
                gnt_id_o = ID_W'(j);
            end
        end
    end

    // Remember the thread just served
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= ID_W'(N - 1);
        end else if (adv_i) begin
            last_q <= gnt_id_o;
        end
    end

    AST_ADV_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> any_o); // R9

endmodule

// File: rtl/ttp_prefetch_gen.sv
// Top of the pop-streak prefetch generator. Routes push/pop events to the
// per-thread slots, picks one thread with work, reads the chosen entry
// from the external storage port and holds it in an output register
// driven on a valid/ready handshake. Assumes the storage port returns the
// entry combinationally and that storage contents match ev_count_i.
module ttp_prefetch_gen #(
    parameter int NUM_THREADS = 4,
    parameter int STACK_DEPTH = 16,
    parameter int ADDR_W      = 32,
    parameter int PF_CAP      = 4,
    parameter int BFS_AHEAD   = 4,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int CNT_W      = $clog2(STACK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bfs_mode_i,
    input  logic              ev_valid_i,
    input  logic              ev_pop_i,
    input  logic [TID_W-1:0]  ev_tid_i,
    input  logic [CNT_W-1:0]  ev_count_i,
    output logic [TID_W-1:0]  rd_tid_o,
    output logic [CNT_W-1:0]  rd_idx_o,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              pf_valid_o,
    input  logic              pf_ready_i,
    output logic [TID_W-1:0]  pf_tid_o,
    output logic [ADDR_W-1:0] pf_addr_o
);

    logic                   mode_q;
    logic                   clr;
    logic [NUM_THREADS-1:0] pend;
    logic [NUM_THREADS-1:0] take;
    logic [NUM_THREADS-1:0] gnt;
    logic [CNT_W-1:0]       cand [NUM_THREADS];
    logic                   any_pend;
    logic [TID_W-1:0]       gnt_id;
    logic                   load_ok;
    logic                   load_fire;

    // Remember the mode so that a change can flush all threads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else begin
            mode_q <= bfs_mode_i;
        end
    end

    assign clr = (bfs_mode_i != mode_q);

    // One state slot per thread
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_slot
        ttp_streak_slot #(
            .STACK_DEPTH (STACK_DEPTH),
            .PF_CAP      (PF_CAP),
            .BFS_AHEAD   (BFS_AHEAD)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (clr),
            .bfs_i   (bfs_mode_i),
            .hit_i   (ev_valid_i && (ev_tid_i == TID_W'(t))),
            .pop_i   (ev_pop_i),
            .count_i (ev_count_i),
            .take_i  (take[t]),
            .pend_o  (pend[t]),
            .cand_o  (cand[t])
        );
    end

    ttp_rr_pick #(
        .N (NUM_THREADS)
    ) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (pend),
        .adv_i    (load_fire),
        .any_o    (any_pend),
        .gnt_o    (gnt),
        .gnt_id_o (gnt_id)
    );

    // Load only in event-free cycles when the output register is free
    always_comb begin
        load_ok   = !ev_valid_i && !clr && (!pf_valid_o || pf_ready_i);
        load_fire = load_ok && any_pend;
        take      = load_fire ? gnt : '0;
        rd_tid_o  = gnt_id;
        rd_idx_o  = cand[gnt_id];
    end

    // Output register with valid/ready hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid_o <= 1'b0;
            pf_tid_o   <= '0;
            pf_addr_o  <= '0;
        end else begin
            if (pf_valid_o && pf_ready_i) begin
                pf_valid_o <= 1'b0;
            end
            if (load_fire) begin
                pf_valid_o <= 1'b1;
                pf_tid_o   <= gnt_id;
                pf_addr_o  <= rd_addr_i;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !pf_valid_o); // R1
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid_o && !pf_ready_i |=> pf_valid_o && $stable(pf_addr_o) && $stable(pf_tid_o)); // R8
    AST_EVENT_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid_i && !pf_valid_o |=> !pf_valid_o); // R2
    AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !any_pend); // R10

endmodule

// File: tb/tb_ttp_prefetch_gen.sv
`timescale 1ns/1ps
module tb_ttp_prefetch_gen;

    localparam int NT = 4;
    localparam int SD = 16;
    localparam int AW = 32;
    localparam int TW = 2;
    localparam int CW = 5;
    localparam int K_IDLE = 0;
    localparam int K_PUSH = 1;
    localparam int K_POP  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bfs_mode = 1'b0;
    logic          ev_valid = 1'b0;
    logic          ev_pop = 1'b0;
    logic [TW-1:0] ev_tid = '0;
    logic [CW-1:0] ev_count = '0;
    logic [TW-1:0] rd_tid;
    logic [CW-1:0] rd_idx;
    logic [AW-1:0] rd_addr;
    logic          pf_valid;
    logic          pf_ready = 1'b1;
    logic [TW-1:0] pf_tid;
    logic [AW-1:0] pf_addr;

    logic [AW-1:0] mem [NT][SD+1];
    int            cnt_m [NT];
    int            checks = 0;
    int            failures = 0;

    always #4 clk = ~clk;

    assign rd_addr = mem[rd_tid][rd_idx];

    ttp_prefetch_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bfs_mode_i (bfs_mode),
        .ev_valid_i (ev_valid),
        .ev_pop_i   (ev_pop),
        .ev_tid_i   (ev_tid),
        .ev_count_i (ev_count),
        .rd_tid_o   (rd_tid),
        .rd_idx_o   (rd_idx),
        .rd_addr_i  (rd_addr),
        .pf_valid_o (pf_valid),
        .pf_ready_i (pf_ready),
        .pf_tid_o   (pf_tid),
        .pf_addr_o  (pf_addr)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic [1:0]  tid;
        logic [31:0] addr;
        logic        rdy;
        logic        ev;
        logic [31:0] ea;
        logic [3:0]  req;
    } vec_t;

    // Depth-first walk on thread 0; each row is one cycle, checked after its edge
    localparam int NV = 33;
    localparam vec_t TBL [NV] = '{
        '{2'd1, 2'd0, 32'h1000, 1'b1, 1'b0, 32'h0,    4'd5},  // R5 pushes only
        '{2'd1, 2'd0, 32'h1010, 1'b1, 1'b0, 32'h0,    4'd5},
        '{2'd1, 2'd0, 32'h1020, 1'b1, 1'b0, 32'h0,    4'd5},
        '{2'd1, 2'd0, 32'h1030, 1'b1, 1'b0, 32'h0,    4'd5},
        '{2'd1, 2'd0, 32'h1040, 1'b1, 1'b0, 32'h0,    4'd5},
        '{2'd1, 2'd0, 32'h1050, 1'b1, 1'b0, 32'h0,    4'd5},
        '{2'd2, 2'd0, 32'h0,    1'b1, 1'b0, 32'h0,    4'd2},  // R2 first pop
        '{2'd0, 2'd0, 32'h0,    1'b1, 1'b1, 32'h1040, 4'd2},
        '{2'd0, 2'd0, 32'h0,    1'b1, 1'b0, 32'h0,    4'd2},
        '{2'd2, 2'd0, 32'h0,    1'b1, 1'b0, 32'h0,    4'd3},  // R3 second pop
        '{2'd0, 2'd0, 32'h0,    1'b1, 1'b1, 32'h1030, 4'd3},
        '{2'd0, 2'd0, 32'h0,    1'b1, 1'b1, 32'h1020, 4'd3},
        '{2'd0, 2'd0, 32'h0,    1'b1, 1'b0, 32'h0,    4'd3},
        '{2'd2, 2'd0, 32'h0,    1'b1, 1'b0, 32'h0,    4'd4},  // R4 third pop
        '{2'd0, 2'd0, 32'h0,    1'b1, 1'b1, 32'h1010, 4'd4},
        '{2'd0, 2'd0, 32'h0,    1'b0, 1'b1, 32'h1010, 4'd8},  // R8 hold
        '{2'd0, 2'd0, 32'h0,    1'b0, 1'b1, 32'h1010, 4'd8},
        '{2'd0, 2'd0, 32'h0,    1'b1, 1'b1, 32'h1000, 4'd8},
        '{2'd0, 2'd0, 32'h0,    1'b1, 1'b0, 32'h0,    4'd6},  // R6 bottom reached
        '{2'd1, 2'd0, 32'h1060, 1'b1, 1'b0, 32'h0,    4'd5},
        '{2'd2, 2'd0, 32'h0,    1'b1, 1'b0, 32'h0,    4'd5},
        '{2'd0, 2'd0, 32'h0,    1'b1, 1'b1, 32'h1020, 4'd5},  // R5 run restarts
        '{2'd0, 2'd0, 32'h0,    1'b1, 1'b0, 32'h0,    4'd5},
        '{2'd2, 2'd0, 32'h0,    1'b1, 1'b0, 32'h0,    4'd3},
        '{2'd1, 2'd0, 32'h1070, 1'b1, 1'b0, 32'h0,    4'd5},  // R5 drops pending
        '{2'd0, 2'd0, 32'h0,    1'b1, 1'b0, 32'h0,    4'd5},
        '{2'd0, 2'd0, 32'h0,    1'b1, 1'b0, 32'h0,    4'd5},
        '{2'd2, 2'd0, 32'h0,    1'b1, 1'b0, 32'h0,    4'd6},
        '{2'd0, 2'd0, 32'h0,    1'b1, 1'b1, 32'h1010, 4'd6},
        '{2'd2, 2'd0, 32'h0,    1'b1, 1'b0, 32'h0,    4'd6},
        '{2'd0, 2'd0, 32'h0,    1'b1, 1'b1, 32'h1000, 4'd6},
        '{2'd2, 2'd0, 32'h0,    1'b1, 1'b0, 32'h0,    4'd6},
        '{2'd0, 2'd0, 32'h0,    1'b1, 1'b0, 32'h0,    4'd6}   // R6 empty stack
    };

    // One cycle: drive at the falling edge, storage model follows the event
    task automatic step(input int kind, input int tid, input logic [AW-1:0] a, input logic rdy);
        ev_valid = (kind == K_PUSH) || (kind == K_POP);
        ev_pop   = (kind == K_POP);
        ev_tid   = TW'(tid);
        pf_ready = rdy;
        if (kind == K_PUSH) begin
            mem[tid][cnt_m[tid]] = a;
            cnt_m[tid]++;
        end else if (kind == K_POP) begin
            if (bfs_mode) begin
                for (int i = 0; i < SD; i++) mem[tid][i] = mem[tid][i+1];
            end
            cnt_m[tid]--;
        end
        ev_count = CW'(cnt_m[tid]);
        @(posedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
        ev_pop   = 1'b0;
    endtask

    task automatic chk(input logic ev, input logic [AW-1:0] ea, input int et, input string req);
        checks++;
        if (pf_valid !== ev || (ev && pf_addr !== ea) || (ev && et >= 0 && pf_tid !== TW'(et))) begin
            failures++;
            $display("FAIL %s: got valid=%0b addr=%h tid=%0d, expected valid=%0b addr=%h tid=%0d",
                     req, pf_valid, pf_addr, pf_tid, ev, ea, et);
        end
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        ev_valid = 1'b0;
        bfs_mode = 1'b0;
        pf_ready = 1'b1;
        for (int t = 0; t < NT; t++) cnt_m[t] = 0;
        repeat (2) @(negedge clk);
        chk(1'b0, '0, -1, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(1'b0, '0, -1, "R1 after reset");
    endtask

    initial begin
        for (int t = 0; t < NT; t++)
            for (int i = 0; i <= SD; i++) mem[t][i] = '0;
        @(negedge clk);
        do_reset();

        // Table of depth-first vectors
        for (int i = 0; i < NV; i++) begin
            step(int'(TBL[i].kind), int'(TBL[i].tid), TBL[i].addr, TBL[i].rdy);
            chk(TBL[i].ev, TBL[i].ea, -1, $sformatf("R%0d row %0d", TBL[i].req, i));
        end

        // R4: cap of four entries after three pops on an eight-deep stack
        do_reset();
        for (int i = 0; i < 8; i++) step(K_PUSH, 1, 32'h5000 + 32'(16 * i), 1'b1);
        for (int i = 0; i < 3; i++) begin
            step(K_POP, 1, '0, 1'b1);
            chk(1'b0, '0, -1, "R4 no issue on pop cycle");
        end
        for (int i = 4; i >= 1; i--) begin
            step(K_IDLE, 0, '0, 1'b1);
            chk(1'b1, 32'h5000 + 32'(16 * i), 1, "R4 capped depth");
        end
        step(K_IDLE, 0, '0, 1'b1);
        chk(1'b0, '0, -1, "R4 stops at cap");

        // R9: two threads with two entries each are interleaved
        do_reset();
        for (int i = 0; i < 6; i++) step(K_PUSH, 0, 32'h2000 + 32'(16 * i), 1'b1);
        for (int i = 0; i < 6; i++) step(K_PUSH, 1, 32'h2100 + 32'(16 * i), 1'b1);
        step(K_POP, 0, '0, 1'b1);
        step(K_POP, 0, '0, 1'b1);
        step(K_POP, 1, '0, 1'b1);
        step(K_POP, 1, '0, 1'b1);
        step(K_IDLE, 0, '0, 1'b1); chk(1'b1, 32'h2030, 0, "R9 thread 0 first");
        step(K_IDLE, 0, '0, 1'b1); chk(1'b1, 32'h2130, 1, "R9 thread 1 next");
        step(K_IDLE, 0, '0, 1'b1); chk(1'b1, 32'h2020, 0, "R9 back to thread 0");
        step(K_IDLE, 0, '0, 1'b1); chk(1'b1, 32'h2120, 1, "R9 thread 1 last");
        step(K_IDLE, 0, '0, 1'b1); chk(1'b0, '0, -1, "R9 drained");

        // R10: a mode change discards a waiting prefetch
        do_reset();
        step(K_PUSH, 2, 32'h4000, 1'b1);
        step(K_PUSH, 2, 32'h4010, 1'b1);
        step(K_POP, 2, '0, 1'b1);
        bfs_mode = 1'b1;
        for (int t = 0; t < NT; t++) cnt_m[t] = 0;
        step(K_IDLE, 0, '0, 1'b1); chk(1'b0, '0, -1, "R10 flush cycle");
        step(K_IDLE, 0, '0, 1'b1); chk(1'b0, '0, -1, "R10 nothing left");

        // R7: breadth-first window of four from the head
        for (int i = 0; i < 6; i++) begin
            step(K_PUSH, 2, 32'h3000 + 32'(16 * i), 1'b1);
            chk(1'b0, '0, -1, "R7 enqueue cycle");
        end
        for (int i = 0; i < 4; i++) begin
            step(K_IDLE, 0, '0, 1'b1);
            chk(1'b1, 32'h3000 + 32'(16 * i), 2, "R7 head window");
        end
        step(K_IDLE, 0, '0, 1'b1); chk(1'b0, '0, -1, "R7 window full");
        step(K_POP, 2, '0, 1'b1);  chk(1'b0, '0, -1, "R7 dequeue cycle");
        step(K_IDLE, 0, '0, 1'b1); chk(1'b1, 32'h3040, 2, "R7 window slides");
        step(K_IDLE, 0, '0, 1'b1); chk(1'b0, '0, -1, "R7 no repeat");
        step(K_PUSH, 3, 32'h3800, 1'b1);
        step(K_PUSH, 3, 32'h3810, 1'b1);
        step(K_IDLE, 0, '0, 1'b1); chk(1'b1, 32'h3800, 3, "R7 short queue head");
        step(K_IDLE, 0, '0, 1'b1); chk(1'b1, 32'h3810, 3, "R7 short queue tail");
        step(K_IDLE, 0, '0, 1'b1); chk(1'b0, '0, -1, "R7 stops at tail");
        step(K_PUSH, 3, 32'h3820, 1'b1);
        step(K_IDLE, 0, '0, 1'b1); chk(1'b1, 32'h3820, 3, "R7 new tail entry");
        step(K_IDLE, 0, '0, 1'b1); chk(1'b0, '0, -1, "R7 no reissue");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule